// File: doc/BRIEF.md
# Hold-Mode Wake Controller

This block tracks the power mode of a small 4-bit microcontroller and gates its core clock. In run mode the core clocks normally. A one-cycle hold command from the core moves the block into hold: the core clock enable drops, and the peripheral clock enable stays high so the timer/counter, serial port and interrupt logic keep running. A one-cycle stop command moves the block into stop, where both enables drop and only reset brings the block back.

Software chooses which events end hold by writing three 4-bit wake-enable registers on a small register bus. Eight wake sources arrive as level or pulse inputs. When an enabled source fires in hold, the block returns to run mode and re-enables the core clock. On that same cycle it sends the core a one-cycle indication: either plain resume, or a vector request naming the interrupt source to service. The block has no data streams, so every pin is a plain control or status signal with no valid/ready handshake. Bus writes take effect at the clock edge, and reads are combinational and always accepted.

Top module: `hold_wake_ctrl`

## Requirements
- R1: After reset, `mode_o` is 0 (run), `core_clk_en` and `periph_clk_en` are 1, `resume_o` and `vector_o` are 0, and all three wake-enable registers read 0.
- R2: The registers sit at 0x36, 0x37 and 0x38. Register 0x36 uses bit0 for the timer and bit1 for the counter. Register 0x37 uses bit0 for serial, bit1 for INT0 and bit2 for the comparator. Register 0x38 uses bit0 for P4.0, bit1 for P4.1 and bit2 for P4.2. Unused bits (0x36 bits 3:2, and bit3 of 0x37 and 0x38) always read 0. Any other address reads 0, and writes to it change no register.
- R3: A `hold_cmd` pulse in run mode sets `mode_o` to 1 (hold) at the next edge. `core_clk_en` falls one edge later.
- R4: In hold, a wake input whose enable bit is clear has no effect: the mode stays hold, the core clock stays off and no indication is given.
- R5: An enabled wake in hold sets `mode_o` to 0 at the next edge. At the edge after that, `core_clk_en` rises together with a one-cycle `resume_o` pulse.
- R6: The wake source index order is 0 timer, 1 counter, 2 serial, 3 INT0, 4 comparator, 5 P4.0, 6 P4.1, 7 P4.2, and `irq_en` uses the same order. If any releasing source also has its `irq_en` bit set, the block gives a one-cycle `vector_o` pulse instead of `resume_o`. In that case `vector_id` is the lowest such index.
- R7: An enabled wake in the same cycle as `hold_cmd` still releases hold one edge after hold is entered.
- R8: `stop_cmd` in run mode sets `mode_o` to 2 (stop), with priority over `hold_cmd`. In stop, `periph_clk_en` is 0 and `core_clk_en` falls one edge later. Only reset leaves stop.
- R9: `periph_clk_en` stays 1 throughout hold.
- R10: Wake inputs in run mode have no effect: there are no pulses and no mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_cmd | input | 1 | One-cycle hold request from the core |
| stop_cmd | input | 1 | One-cycle stop request from the core |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 4 | Register write data |
| bus_rdata | output | 4 | Register read data (combinational) |
| wake_evt | input | 8 | Wake event inputs, index order per R6 |
| irq_en | input | 8 | Interrupt-enabled sources, same order |
| mode_o | output | 2 | 0 run, 1 hold, 2 stop |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| resume_o | output | 1 | One-cycle plain resume after release |
| vector_o | output | 1 | One-cycle vector request after release |
| vector_id | output | 3 | Source index, valid with `vector_o` |

## Verification
Some properties are checked on every cycle:
- the core clock is off on the edge after hold is entered;
- hold persists while no enabled wake is seen;
- resume and vector never pulse together, and each pulses only while the core clock is on;
- stop is sticky;
- the peripheral clock stays on in hold;
- reserved register bits read as zero.

Only the directed scenarios can show the rest:
- the exact two-edge release latency;
- the priority choice of `vector_id`;
- the capture of a wake that coincides with the hold command;
- masking of disabled sources;
- that run-mode wakes and writes to unmapped addresses change nothing.

// File: rtl/hold_wake_pkg.sv
package hold_wake_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_HOLD = 2'b01,
    MODE_STOP = 2'b10
  } pwr_mode_e;

  localparam int REG0_BITS = 2;  // timer, counter
  localparam int REGX_BITS = 3;  // serial/int0/cmp and p4.0..p4.2
  localparam int SRC_N     = REG0_BITS + 2 * REGX_BITS;
  localparam int SRC_IDW   = $clog2(SRC_N);
endpackage

// File: rtl/hwc_cfg_regs.sv
module hwc_cfg_regs
  import hold_wake_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [SRC_N-1:0]  wake_en
);
  localparam int NREG = 3;

  logic [DATA_W-1:0] cfg_q   [NREG];
  logic [DATA_W-1:0] rd_part [NREG];
  logic [NREG-1:0]   sel;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = BASE_ADDR + ADDR_W'(g);
    localparam int USED = (g == 0) ? REG0_BITS : REGX_BITS;
    localparam logic [DATA_W-1:0] KEEP = DATA_W'((1 << USED) - 1);

    assign sel[g] = (bus_addr == MY_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cfg_q[g] <= '0;
      else if (bus_we && sel[g]) cfg_q[g] <= bus_wdata & KEEP;
    end

    assign rd_part[g] = sel[g] ? cfg_q[g] : '0;
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NREG; i++) bus_rdata |= rd_part[i];
  end

  assign wake_en = {cfg_q[2][REGX_BITS-1:0], cfg_q[1][REGX_BITS-1:0],
                    cfg_q[0][REG0_BITS-1:0]};

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[1] || sel[2]) |-> (bus_rdata[DATA_W-1] == 1'b0));
endmodule

// File: rtl/hwc_wake_sel.sv
module hwc_wake_sel
  import hold_wake_pkg::*;
(
  input  logic               armed,
  input  logic [SRC_N-1:0]   wake_in,
  input  logic [SRC_N-1:0]   wake_en,
  input  logic [SRC_N-1:0]   early_src,
  input  logic [SRC_N-1:0]   irq_en,
  output logic [SRC_N-1:0]   hit_now,
  output logic               release_hit,
  output logic               take_vec,
  output logic [SRC_IDW-1:0] vec_id
);
  logic [SRC_N-1:0] cand;
  logic [SRC_N-1:0] vec_cand;

  assign hit_now     = wake_in & wake_en;
  assign cand        = hit_now | early_src;
  assign release_hit = armed && (|cand);
  assign vec_cand    = cand & irq_en;
  assign take_vec    = |vec_cand;

  always_comb begin
    vec_id = '0;
    for (int i = SRC_N - 1; i >= 0; i--)
      if (vec_cand[i]) vec_id = SRC_IDW'(i);
  end
endmodule

// File: rtl/hwc_mode_fsm.sv
module hwc_mode_fsm
  import hold_wake_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold_cmd,
  input  logic               stop_cmd,
  input  logic [SRC_N-1:0]   hit_now,
  input  logic               release_hit,
  input  logic               take_vec,
  input  logic [SRC_IDW-1:0] vec_id,
  output pwr_mode_e          mode,
  output logic [SRC_N-1:0]   early_src,
  output logic               core_clk_en,
  output logic               periph_clk_en,
  output logic               resume_o,
  output logic               vector_o,
  output logic [SRC_IDW-1:0] vector_id
);
  pwr_mode_e          mode_q;
  logic [SRC_N-1:0]   early_q;
  logic               rel_q, rel_vec_q;
  logic [SRC_IDW-1:0] rel_id_q;
  logic               clk_en_q, resume_q, vector_q;
  logic [SRC_IDW-1:0] vid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_RUN;
      early_q   <= '0;
      rel_q     <= 1'b0;
      rel_vec_q <= 1'b0;
      rel_id_q  <= '0;
    end else begin
      rel_q <= 1'b0;
      case (mode_q)
        MODE_RUN: begin
          if (stop_cmd) mode_q <= MODE_STOP;
          else if (hold_cmd) begin
            mode_q  <= MODE_HOLD;
            early_q <= hit_now;  // wake coinciding with the hold command
          end
        end
        MODE_HOLD: begin
          if (release_hit) begin
            mode_q    <= MODE_RUN;
            early_q   <= '0;
            rel_q     <= 1'b1;
            rel_vec_q <= take_vec;
            rel_id_q  <= vec_id;
          end
        end
        default: mode_q <= MODE_STOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en_q <= 1'b1;
      resume_q <= 1'b0;
      vector_q <= 1'b0;
      vid_q    <= '0;
    end else begin
      clk_en_q <= (mode_q == MODE_RUN);
      resume_q <= rel_q && !rel_vec_q;
      vector_q <= rel_q && rel_vec_q;
      if (rel_q && rel_vec_q) vid_q <= rel_id_q;
    end
  end

  assign mode          = mode_q;
  assign early_src     = early_q;
  assign core_clk_en   = clk_en_q;
  assign periph_clk_en = (mode_q != MODE_STOP);
  assign resume_o      = resume_q;
  assign vector_o      = vector_q;
  assign vector_id     = vid_q;

  assert_gate_after_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q == MODE_HOLD) |=> !clk_en_q);
  assert_hold_persists_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_HOLD && !release_hit) |=> (mode_q == MODE_HOLD));
  assert_single_indication_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resume_q, vector_q}));
  assert_indication_with_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_q || vector_q) |-> clk_en_q);
  assert_resume_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resume_q |=> !resume_q);
  assert_stop_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STOP) |=> (mode_q == MODE_STOP));
  assert_periph_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_HOLD) |-> periph_clk_en);
endmodule

// File: rtl/hold_wake_ctrl.sv
module hold_wake_ctrl
  import hold_wake_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h36
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold_cmd,
  input  logic               stop_cmd,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [SRC_N-1:0]   wake_evt,
  input  logic [SRC_N-1:0]   irq_en,
  output logic [1:0]         mode_o,
  output logic               core_clk_en,
  output logic               periph_clk_en,
  output logic               resume_o,
  output logic               vector_o,
  output logic [SRC_IDW-1:0] vector_id
);
  logic [SRC_N-1:0]   wake_en, hit_now, early_src;
  logic               release_hit, take_vec;
  logic [SRC_IDW-1:0] vec_id;
  pwr_mode_e          mode;

  hwc_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_en(wake_en)
  );

  hwc_wake_sel u_sel (
    .armed(mode == MODE_HOLD), .wake_in(wake_evt), .wake_en(wake_en),
    .early_src(early_src), .irq_en(irq_en), .hit_now(hit_now),
    .release_hit(release_hit), .take_vec(take_vec), .vec_id(vec_id)
  );

  hwc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hold_cmd(hold_cmd), .stop_cmd(stop_cmd),
    .hit_now(hit_now), .release_hit(release_hit), .take_vec(take_vec),
    .vec_id(vec_id), .mode(mode), .early_src(early_src),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .resume_o(resume_o), .vector_o(vector_o), .vector_id(vector_id)
  );

  assign mode_o = mode;

  assert_no_run_wake_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RUN && !hold_cmd && !stop_cmd) |=> (mode == MODE_RUN));
endmodule

// File: tb/test_hold_wake_ctrl.sv
module test_hold_wake_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       hold_cmd = 0, stop_cmd = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [3:0] bus_wdata = 0, bus_rdata;
  logic [7:0] wake_evt = 0, irq_en = 0;
  logic [1:0] mode_o;
  logic       core_clk_en, periph_clk_en, resume_o, vector_o;
  logic [2:0] vector_id;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  hold_wake_ctrl i_hold_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .hold_cmd(hold_cmd), .stop_cmd(stop_cmd),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wake_evt(wake_evt), .irq_en(irq_en),
    .mode_o(mode_o), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .resume_o(resume_o), .vector_o(vector_o), .vector_id(vector_id)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [7:0] a, logic [3:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd_check(string tag, logic [7:0] a, logic [3:0] exp);
    @(negedge clk); bus_addr = a; #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; hold_cmd = 0; stop_cmd = 0; wake_evt = 0; irq_en = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic enter_hold(string tag);
    @(negedge clk); hold_cmd = 1;
    tick(); check({tag, " mode hold"}, mode_o, 1); check({tag, " clk still on"}, core_clk_en, 1);
    @(negedge clk); hold_cmd = 0;
    tick(); check({tag, " clk off"}, core_clk_en, 0); check({tag, " periph on"}, periph_clk_en, 1);
  endtask

  task automatic release_by(string tag, logic [7:0] w, logic exp_vec, logic [2:0] exp_id);
    @(negedge clk); wake_evt = w;
    tick(); check({tag, " mode run"}, mode_o, 0); check({tag, " clk off yet"}, core_clk_en, 0);
    check({tag, " no early pulse"}, {resume_o, vector_o}, 0);
    @(negedge clk); wake_evt = 0;
    tick(); check({tag, " clk on"}, core_clk_en, 1);
    check({tag, " resume"}, resume_o, !exp_vec); check({tag, " vector"}, vector_o, exp_vec);
    if (exp_vec) check({tag, " vector_id"}, vector_id, exp_id);
    tick(); check({tag, " pulse ends"}, {resume_o, vector_o}, 0);
  endtask

  task automatic t_reset();
    check("R1 mode", mode_o, 0); check("R1 core clk", core_clk_en, 1);
    check("R1 periph clk", periph_clk_en, 1); check("R1 pulses", {resume_o, vector_o}, 0);
    rd_check("R1 reg36", 8'h36, 0); rd_check("R1 reg37", 8'h37, 0); rd_check("R1 reg38", 8'h38, 0);
  endtask

  task automatic t_regs();
    wr(8'h36, 4'hF); wr(8'h37, 4'hF); wr(8'h38, 4'hF); wr(8'h40, 4'hF); wr(8'h35, 4'hF);
    rd_check("R2 reg36 mask", 8'h36, 4'h3); rd_check("R2 reg37 mask", 8'h37, 4'h7);
    rd_check("R2 reg38 mask", 8'h38, 4'h7); rd_check("R2 unmapped read", 8'h40, 4'h0);
    wr(8'h37, 4'h5); rd_check("R2 reg37 rewrite", 8'h37, 4'h5);
    rd_check("R2 reg36 unchanged", 8'h36, 4'h3);
  endtask

  task automatic t_hold_ignore();
    wr(8'h36, 0); wr(8'h37, 0); wr(8'h38, 0);
    enter_hold("R3");
    @(negedge clk); wake_evt = 8'hFF;
    for (int i = 0; i < 3; i++) begin
      tick(); check("R4 stays hold", mode_o, 1); check("R4 clk stays off", core_clk_en, 0);
      check("R4 no pulse", {resume_o, vector_o}, 0); check("R9 periph on", periph_clk_en, 1);
    end
    @(negedge clk); wake_evt = 0;
    wr(8'h37, 4'h1);  // serial enabled while in hold
    release_by("R5 serial", 8'h04, 0, 0);
  endtask

  task automatic t_vector();
    wr(8'h36, 4'h3); wr(8'h37, 4'h7); wr(8'h38, 4'h7);
    irq_en = 8'b0010_1000;
    enter_hold("R6a");
    release_by("R6 lowest id", 8'h2C, 1, 3'd3);
    enter_hold("R6b");
    release_by("R6 no irq resume", 8'h10, 0, 0);
    irq_en = 0;
  endtask

  task automatic t_same_cycle();
    wr(8'h36, 0); wr(8'h37, 0); wr(8'h38, 4'h2);
    @(negedge clk); hold_cmd = 1; wake_evt = 8'h40;
    tick(); check("R7 mode hold", mode_o, 1);
    @(negedge clk); hold_cmd = 0; wake_evt = 0;
    tick(); check("R7 released", mode_o, 0); check("R7 clk off", core_clk_en, 0);
    tick(); check("R7 clk on", core_clk_en, 1); check("R7 resume", resume_o, 1);
  endtask

  task automatic t_run_wake();
    wr(8'h36, 4'h3); wr(8'h37, 4'h7); wr(8'h38, 4'h7);
    @(negedge clk); wake_evt = 8'hFF; irq_en = 8'hFF;
    for (int i = 0; i < 2; i++) begin
      tick(); check("R10 mode run", mode_o, 0); check("R10 no pulse", {resume_o, vector_o}, 0);
      check("R10 clk on", core_clk_en, 1);
    end
    @(negedge clk); wake_evt = 0; irq_en = 0;
  endtask

  task automatic t_stop();
    @(negedge clk); stop_cmd = 1; hold_cmd = 1;
    tick(); check("R8 mode stop", mode_o, 2); check("R8 periph off", periph_clk_en, 0);
    @(negedge clk); stop_cmd = 0; hold_cmd = 0; wake_evt = 8'hFF;
    tick(); check("R8 clk off", core_clk_en, 0);
    tick(); check("R8 sticky", mode_o, 2); check("R8 no pulse", {resume_o, vector_o}, 0);
    @(negedge clk); wake_evt = 0;
    do_reset(); #1;
    check("R8 reset exits", mode_o, 0); check("R8 clk back", core_clk_en, 1);
    check("R8 periph back", periph_clk_en, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1; #1;
    t_reset();
    t_regs();
    t_hold_ignore();
    t_vector();
    t_same_cycle();
    t_run_wake();
    t_stop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule